// File: doc/BRIEF.md
# Sample-Rate Paced Audio Player

The block streams a buffer of decoded 16-bit audio samples into a DAC data register at a programmable sample rate. A host first writes two configuration words over a small write-only register port: the byte address where the buffer starts, and the sample rate in hertz. It then pulses `start`. A sequential divider turns the rate into a tick period in fabric clock cycles. A down-counter then produces a one-clock pacing tick at that period.

For each sample, the player reads the next 16-bit word over a request/acknowledge memory master port. It holds the word until the next pacing tick arrives. It then writes the word into the DAC with a two-phase setup/access handshake that waits for the DAC's ready signal. Because the fetch runs ahead of the tick, memory latency does not shift the output timing. After the last sample of a fixed-length buffer has been accepted, the block raises `done`. The flag stays high until the next start command.

Top module: `pcm_pacer`

## Requirements
- R1: A configuration write with `cfg_sel`=0 stores the buffer base byte address. A write with `cfg_sel`=1 and a nonzero value stores the sample rate in hertz. A start command does not begin fetching until the tick period for the most recently written rate has been computed.
- R2: While playing, consecutive DAC setup phases are exactly round(CLK_HZ / rate) clock cycles apart, with halves rounded up, provided each fetch and write finish within one period.
- R3: Sample k (k = 0 .. SAMPLES-1) is read from byte address base + 2·k, in increasing order. `mem_req` stays high with a stable `mem_addr` until the cycle in which `mem_ack` is high.
- R4: The value presented on `dac_wdata` is the 16-bit word returned by the memory for the same sample.
- R5: Each DAC write has exactly one setup cycle (`dac_sel`=1, `dac_enable`=0), followed by an access phase (`dac_sel`=1, `dac_enable`=1). The access phase holds stable data until the cycle in which `dac_ready` is high.
- R6: After the SAMPLES-th DAC write is accepted, `done` goes high. No further memory request or DAC select is issued while `done` is high.
- R7: `done` stays high until a start pulse. The start pulse clears it on the next clock edge.
- R8: A start pulse that arrives while a buffer is playing has no effect: the address sequence continues and exactly SAMPLES writes occur.
- R9: During reset `done`, `mem_req`, `dac_sel` and `dac_enable` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base address, 1 selects the sample rate |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | One-cycle playback command |
| done | output | 1 | Buffer fully played |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested sample |
| mem_ack | input | 1 | Memory read acknowledge, qualifies `mem_rdata` |
| mem_rdata | input | 16 | Sample word from memory |
| dac_sel | output | 1 | DAC transfer select |
| dac_enable | output | 1 | DAC access phase |
| dac_wdata | output | 16 | Sample written to the DAC |
| dac_ready | input | 1 | DAC accepts the access |

## Verification
A wrong tick period or a lost pending tick shows up as a setup-to-setup gap that differs from round(CLK_HZ/rate). The bench sees this from the second sample of a buffer onward. A corrupt address or sample counter shows up on the first fetch after the fault, as an address off the base + 2·k line, and at the end as a write count other than SAMPLES with a late or early `done`. A bad latch of the fetched word appears on the next DAC access as a data mismatch. A start that is wrongly accepted mid-buffer resets the address back to the base, and that appears on the very next fetch.

// File: rtl/pcm_pacer_pkg.sv
package pcm_pacer_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ARM,
    PS_FETCH,
    PS_HOLD,
    PS_SETUP,
    PS_ACCESS
  } play_state_e;
endpackage

// File: rtl/pacer_rate_div.sv
// Restoring divider, one quotient bit per clock, MSB first.
module pacer_rate_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q, num_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [DEN_W:0]   rem_sh, rem_diff;
  logic             fits;

  always_comb begin
    rem_sh   = {rem_q, num_q[NUM_W-1]};
    rem_diff = rem_sh - {1'b0, den_q};
    fits     = (rem_sh >= {1'b0, den_q});
    num_d  = num_q;
    den_d  = den_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (go) begin
      num_d  = num;
      den_d  = den;
      rem_d  = '0;
      quo_d  = '0;
      cnt_d  = CNT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      num_d  = {num_q[NUM_W-2:0], 1'b0};
      rem_d  = fits ? rem_diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
      quo_d  = {quo_q[NUM_W-2:0], fits};
      cnt_d  = cnt_q - 1'b1;
      busy_d = (cnt_q != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      num_q  <= num_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign quo  = quo_q;
endmodule

// File: rtl/pacer_tick_gen.sv
// Down-counter giving a one-clock tick every `period` cycles while enabled.
module pacer_tick_gen #(
  parameter int PER_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] reload;

  always_comb begin
    reload = (period == '0) ? '0 : period - 1'b1;
    tick   = en && !load && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (load)       cnt_d = reload;
    else if (tick)  cnt_d = reload;
    else if (en)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pacer_seq.sv
// Playback sequencer: fetch ahead, hold until tick, two-phase DAC write.
module pacer_seq
  import pcm_pacer_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int SAMPLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              div_busy,
  input  logic              tick,
  output logic              tick_load,
  output logic              playing,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dac_sel,
  output logic              dac_enable,
  output logic [DATA_W-1:0] dac_wdata,
  input  logic              dac_ready
);
  localparam int CNT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  play_state_e       st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] smp_q, smp_d;
  logic              pend_q, pend_d;
  logic              done_q, done_d;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    smp_d     = smp_q;
    pend_d    = pend_q || tick;
    done_d    = done_q;
    tick_load = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        pend_d = 1'b0;
        if (start) begin
          done_d = 1'b0;
          addr_d = base;
          cnt_d  = '0;
          st_d   = PS_ARM;
        end
      end
      PS_ARM: begin
        pend_d = 1'b0;
        if (!div_busy) begin
          tick_load = 1'b1;
          st_d      = PS_FETCH;
        end
      end
      PS_FETCH: begin
        if (mem_ack) begin
          smp_d = mem_rdata;
          st_d  = PS_HOLD;
        end
      end
      PS_HOLD: begin
        if (tick || pend_q) begin
          pend_d = 1'b0;
          st_d   = PS_SETUP;
        end
      end
      PS_SETUP: st_d = PS_ACCESS;
      PS_ACCESS: begin
        if (dac_ready) begin
          addr_d = addr_q + STEP;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            done_d = 1'b1;
            st_d   = PS_IDLE;
          end else begin
            st_d = PS_FETCH;
          end
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      smp_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      smp_q  <= smp_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign playing    = (st_q != PS_IDLE) && (st_q != PS_ARM);
  assign done       = done_q;
  assign mem_req    = (st_q == PS_FETCH);
  assign mem_addr   = addr_q;
  assign dac_sel    = (st_q == PS_SETUP) || (st_q == PS_ACCESS);
  assign dac_enable = (st_q == PS_ACCESS);
  assign dac_wdata  = smp_q;
endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer #(
  parameter int CLK_HZ  = 40_000_000,
  parameter int SAMPLES = 4096,
  parameter int ADDR_W  = 32,
  parameter int RATE_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              dac_sel,
  output logic              dac_enable,
  output logic [15:0]       dac_wdata,
  input  logic              dac_ready
);
  localparam int DATA_W = 16;
  localparam int NUM_W  = $clog2(CLK_HZ + (1 << RATE_W)) + 1;

  logic              rst_m_q, rst_s_q;
  logic [ADDR_W-1:0] base_q;
  logic              div_go, div_busy, tick, tick_load, playing;
  logic [RATE_W-1:0] rate_in;
  logic [NUM_W-1:0]  div_num, div_quo, period;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q)                   base_q <= '0;
    else if (cfg_we && !cfg_sel)    base_q <= cfg_wdata[ADDR_W-1:0];
  end

  always_comb begin
    rate_in = cfg_wdata[RATE_W-1:0];
    div_go  = cfg_we && cfg_sel && (rate_in != '0);
    div_num = NUM_W'(CLK_HZ) + NUM_W'(rate_in >> 1);
    period  = (div_quo == '0) ? NUM_W'(1) : div_quo;
  end

  pacer_rate_div #(.NUM_W(NUM_W), .DEN_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_s_q), .go(div_go), .num(div_num), .den(rate_in),
    .busy(div_busy), .quo(div_quo)
  );

  pacer_tick_gen #(.PER_W(NUM_W)) u_tick (
    .clk(clk), .rst_n(rst_s_q), .load(tick_load), .en(playing),
    .period(period), .tick(tick)
  );

  pacer_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLES(SAMPLES)) u_seq (
    .clk(clk), .rst_n(rst_s_q), .start(start), .base(base_q),
    .div_busy(div_busy), .tick(tick), .tick_load(tick_load), .playing(playing),
    .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dac_sel(dac_sel), .dac_enable(dac_enable),
    .dac_wdata(dac_wdata), .dac_ready(dac_ready)
  );
endmodule

// File: rtl/pcm_pacer_chk.sv
module pcm_pacer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              dac_sel,
  input logic              dac_enable,
  input logic [15:0]       dac_wdata,
  input logic              dac_ready
);
  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_setup_to_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sel && !dac_enable) |=> (dac_sel && dac_enable));

  assert_access_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_enable && !dac_ready) |=> (dac_enable && $stable(dac_wdata)));

  assert_enable_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_enable |-> dac_sel);

  assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dac_sel && !mem_req));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);
endmodule

bind pcm_pacer pcm_pacer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .dac_sel(dac_sel),
  .dac_enable(dac_enable), .dac_wdata(dac_wdata), .dac_ready(dac_ready)
);

// File: tb/tb_pcm_pacer.sv
module tb_pcm_pacer;
  localparam int CLK_HZ  = 800_000;
  localparam int SAMPLES = 32;
  localparam int ADDR_W  = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, cfg_we, cfg_sel, start, done;
  logic [31:0]       cfg_wdata;
  logic              mem_req, mem_ack, dac_sel, dac_enable, dac_ready;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0]       mem_rdata, dac_wdata;

  pcm_pacer #(.CLK_HZ(CLK_HZ), .SAMPLES(SAMPLES), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .done(done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dac_sel(dac_sel), .dac_enable(dac_enable), .dac_wdata(dac_wdata),
    .dac_ready(dac_ready)
  );

  int     n_checks = 0, n_err = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mon_base = '0;
  int     mon_fetch = 0, mon_write = 0, mon_per = 1;
  longint prev_setup = -1;
  int     mwait = 0, dwait = 0;

  function automatic logic [15:0] word_at(input logic [31:0] a);
    logic [31:0] h;
    h = (a * 32'd40503) ^ (a >> 5) ^ 32'h5A5A;
    return h[15:0];
  endfunction

  function automatic int exp_period(input int rate);
    return (CLK_HZ + rate / 2) / rate;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Memory responder: random latency, checks address order (R3).
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && rst_n) begin
        if (mwait == 0) begin
          check(mem_addr == mon_base + 32'(2 * mon_fetch), "R3", "fetch address",
                mem_addr, mon_base + 32'(2 * mon_fetch));
          mem_rdata = word_at(mem_addr);
          mem_ack   = 1'b1;
          mon_fetch++;
          mwait = $urandom_range(0, 2);
        end else mwait--;
      end
    end
  end

  // DAC responder: checks pacing (R2), phases (R5) and data (R4).
  initial begin
    dac_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (dac_ready) dac_ready = 1'b0;
      else if (dac_sel && !dac_enable) begin
        if (prev_setup >= 0)
          check(cyc - prev_setup == longint'(mon_per), "R2", "setup spacing",
                cyc - prev_setup, mon_per);
        prev_setup = cyc;
        dwait = $urandom_range(0, 2);
      end else if (dac_enable) begin
        if (dwait == 0) begin
          check(dac_wdata == word_at(mon_base + 32'(2 * mon_write)), "R4", "dac data",
                dac_wdata, word_at(mon_base + 32'(2 * mon_write)));
          dac_ready = 1'b1;
          mon_write++;
        end else dwait--;
      end
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic play(input logic [31:0] base, input int rate, input bit poke);
    bit quiet;
    int guard;
    cfg_write(1'b0, base);
    cfg_write(1'b1, 32'(rate));
    mon_base = base; mon_fetch = 0; mon_write = 0; prev_setup = -1;
    mon_per = exp_period(rate);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R7", "done cleared by start", done, 0);
    if (poke) begin   // R8: start while playing is ignored
      repeat (5 * mon_per) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 40 * SAMPLES * mon_per) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R6", "done raised", done, 1);
    check(mon_write == SAMPLES, poke ? "R8" : "R6", "dac writes", mon_write, SAMPLES);
    check(mon_fetch == SAMPLES, "R3", "fetch count", mon_fetch, SAMPLES);
    quiet = 1'b1;
    repeat (3 * mon_per) begin
      @(negedge clk);
      if (!done || dac_sel || mem_req) quiet = 1'b0;
    end
    check(quiet, "R7", "done held and bus quiet", quiet, 1);
    check(mon_write == SAMPLES, "R6", "no write after done", mon_write, SAMPLES);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !mem_req && !dac_sel && !dac_enable, "R9", "reset outputs",
          {done, mem_req, dac_sel, dac_enable}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    play(32'h0000_1000, 8000, 1'b0);    // slowest rate, exact period
    play(32'h0002_0040, 44100, 1'b0);   // fastest rate, 18.14 -> 18
    play(32'h0000_0100, 11025, 1'b1);   // 72.56 rounds up to 73 (R1), restart ignored
    // R1: rate rewritten just before start must take effect.
    cfg_write(1'b1, 32'd8000);
    play(32'h0000_0200, 22050, 1'b0);
    for (int i = 0; i < 3; i++)
      play({$urandom_range(0, 32'h7FFF), 1'b0} & 32'hFFFF_FFFE,
           $urandom_range(8000, 44100), 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule